// File: doc/BRIEF.md
# Receive Frame Statistics Counter Bank

This block sits behind the receive side of an Ethernet MAC. When a frame ends, the MAC hands it one summary in a single cycle. The summary carries the frame length (FCS included), the FCS verdict, the address class (broadcast or multicast), the pause and control markers, the length-field mismatch and alignment flags, and three drop reasons: receive FIFO overflow, descriptor-ring overflow and address filtering. From that summary the block updates a bank of 24 saturating counters. The bank holds good-frame totals, payload byte totals, a seven-way size histogram, short-frame and error counts, and per-reason drop counts.

Software or a statistics collector reads a counter by putting a 5-bit index on a strobe. The value appears one cycle later. The read also clears that counter, so each read returns the events seen since the last read. The MTU is a live input and sets the upper limit of the largest size bin and the threshold for oversize frames.

Counter indices: 0 good frames, 1 good bytes, 2 broadcast frames, 3 multicast frames, 4 broadcast bytes, 5 multicast bytes, 6 pause frames, 7 other control frames, 8 FCS errors, 9 length-field errors, 10 alignment errors, 11 runts, 12 fragments, 13 oversize frames, 14 FIFO-overflow drops, 15 descriptor drops, 16 filter drops, 17 to 23 size bins (64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, 1519–MTU).

Top module: `rx_stat_bank`

## Requirements
- R1: A frame counts as good when it is not dropped, its length is between 64 and the MTU inclusive, its FCS is good and it has neither a length-field mismatch nor an alignment error. Each good frame adds one to counter 0. A good broadcast frame adds one to counter 2. A good multicast frame that is not broadcast adds one to counter 3.
- R2: For each good frame, counter 1 adds the length minus the 4 FCS bytes. Counter 4 adds the same amount for a good broadcast frame, and counter 5 adds it for a good multicast frame that is not broadcast.
- R3: A good frame adds one to exactly one size bin, counters 17 to 23. The bins are: length 64; 65–127; 128–255; 256–511; 512–1023; 1024–1518; 1519 up to the MTU.
- R4: A frame that is not dropped, is shorter than 64 bytes and has a good FCS adds one to counter 11 (runt). With a bad FCS it adds one to counter 12 (fragment) instead.
- R5: A frame that is not dropped and is longer than the MTU adds one to counter 13 and to no good, size, short-frame or FCS-error counter.
- R6: Each drop flag set on a valid summary adds one to its own counter: 14 for FIFO overflow, 15 for the descriptor ring, 16 for the address filter. A dropped frame changes no other counter.
- R7: A good frame marked pause adds one to counter 6. A good frame marked control and not pause adds one to counter 7.
- R8: A frame that is not dropped, has length 64 to MTU and a bad FCS adds one to counter 8. A frame that is not dropped and has a length-field mismatch adds one to counter 9. A frame that is not dropped and has an alignment error adds one to counter 10.
- R9: A strobe with index k makes rd_valid high on the next cycle, and rd_data then holds counter k. Indices 24 to 31 return zero. rd_valid is low in every cycle that does not follow a strobe.
- R10: A read leaves the counter it selected at zero when no event hits that counter in the same cycle.
- R11: When a read and an increment hit the same counter in one cycle, the read returns the value from before that increment, and the counter then holds only that cycle's increment.
- R12: A counter that would pass its maximum value holds at all ones instead of wrapping.
- R13: After reset every counter reads zero and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Frame summary present this cycle |
| frm_len | input | 14 | Frame length in bytes, FCS included |
| frm_fcs_ok | input | 1 | FCS checked good |
| frm_bcast | input | 1 | Broadcast destination |
| frm_mcast | input | 1 | Multicast destination |
| frm_pause | input | 1 | Pause frame |
| frm_ctrl | input | 1 | MAC control frame |
| frm_len_mis | input | 1 | Length field disagrees with actual size |
| frm_align_err | input | 1 | Alignment error |
| frm_drop_fifo | input | 1 | Dropped on receive FIFO overflow |
| frm_drop_desc | input | 1 | Dropped on descriptor-ring overflow |
| frm_drop_filt | input | 1 | Dropped by address filter |
| mtu | input | 14 | Largest accepted length, FCS included (at least 64) |
| rd_stb | input | 1 | Read-and-clear strobe |
| rd_idx | input | 5 | Counter index to read |
| rd_valid | output | 1 | Read data valid, one cycle after strobe |
| rd_data | output | CNT_W (32) | Counter value read |

## Verification
Two operations can fall in the same cycle: a read-and-clear of a counter, and a frame summary that increments that same counter. The bench causes this both with directed reads issued in the same cycle as matching frames and with a long random phase in which strobes and summaries overlap freely. Its model takes the old value as the read result and then rebuilds the counter from zero plus that cycle's increment. A later read of the counter must then return exactly that increment.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

    localparam int LEN_W     = 14;
    localparam int IDX_W     = 5;
    localparam int NUM_BIN   = 7;
    localparam int NUM_CNT   = 17 + NUM_BIN;
    localparam int MIN_LEN   = 64;
    localparam int FCS_BYTES = 4;

    // counter indices
    localparam int IX_GOOD      = 0;
    localparam int IX_GOOD_B    = 1;
    localparam int IX_BC        = 2;
    localparam int IX_MC        = 3;
    localparam int IX_BC_B      = 4;
    localparam int IX_MC_B      = 5;
    localparam int IX_PAUSE     = 6;
    localparam int IX_CTRL      = 7;
    localparam int IX_FCS_ERR   = 8;
    localparam int IX_LEN_ERR   = 9;
    localparam int IX_ALIGN     = 10;
    localparam int IX_RUNT      = 11;
    localparam int IX_FRAG      = 12;
    localparam int IX_OVER      = 13;
    localparam int IX_DROP_FIFO = 14;
    localparam int IX_DROP_DESC = 15;
    localparam int IX_DROP_FILT = 16;
    localparam int IX_BIN0      = 17;

    // lower edge of each size bin; upper edge is the next lower edge minus one,
    // the last bin ends at the MTU
    localparam int BIN_LO [NUM_BIN] = '{64, 65, 128, 256, 512, 1024, 1519};

    typedef struct packed {
        logic             valid;
        logic [LEN_W-1:0] len;
        logic             fcs_ok;
        logic             bcast;
        logic             mcast;
        logic             pause;
        logic             ctrl;
        logic             len_mis;
        logic             align;
        logic             drop_fifo;
        logic             drop_desc;
        logic             drop_filt;
    } frame_sum_t;

endpackage

// File: rtl/rx_stat_classify.sv
module rx_stat_classify
    import rx_stat_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  frame_sum_t                        fs,
    input  logic [LEN_W-1:0]                  mtu,
    output logic [NUM_CNT-1:0][LEN_W-1:0]     amt
);

    logic             drop;
    logic             live;
    logic             over;
    logic             short_f;
    logic             fcs_bad;
    logic             good;
    logic             bc_only;
    logic             mc_only;
    logic [LEN_W-1:0] payload;
    logic [NUM_BIN-1:0] in_bin;

    genvar b;
    generate
        for (b = 0; b < NUM_BIN; b++) begin : g_bin
            if (b == NUM_BIN - 1) begin : g_top
                assign in_bin[b] = (fs.len >= LEN_W'(BIN_LO[b])) && (fs.len <= mtu);
            end else begin : g_mid
                assign in_bin[b] = (fs.len >= LEN_W'(BIN_LO[b])) &&
                                   (fs.len <  LEN_W'(BIN_LO[b+1]));
            end
        end
    endgenerate

    always_comb begin
        drop    = fs.drop_fifo | fs.drop_desc | fs.drop_filt;
        live    = fs.valid && !drop;
        over    = live && (fs.len > mtu);
        short_f = live && !over && (fs.len < LEN_W'(MIN_LEN));
        fcs_bad = live && !over && !short_f && !fs.fcs_ok;
        good    = live && !over && !short_f && fs.fcs_ok && !fs.len_mis && !fs.align;
        bc_only = good && fs.bcast;
        mc_only = good && fs.mcast && !fs.bcast;
        payload = fs.len - LEN_W'(FCS_BYTES);

        amt = '0;
        amt[IX_DROP_FIFO] = LEN_W'(fs.valid && fs.drop_fifo);
        amt[IX_DROP_DESC] = LEN_W'(fs.valid && fs.drop_desc);
        amt[IX_DROP_FILT] = LEN_W'(fs.valid && fs.drop_filt);
        amt[IX_OVER]      = LEN_W'(over);
        amt[IX_RUNT]      = LEN_W'(short_f && fs.fcs_ok);
        amt[IX_FRAG]      = LEN_W'(short_f && !fs.fcs_ok);
        amt[IX_FCS_ERR]   = LEN_W'(fcs_bad);
        amt[IX_LEN_ERR]   = LEN_W'(live && fs.len_mis);
        amt[IX_ALIGN]     = LEN_W'(live && fs.align);
        amt[IX_GOOD]      = LEN_W'(good);
        amt[IX_GOOD_B]    = good ? payload : '0;
        amt[IX_BC]        = LEN_W'(bc_only);
        amt[IX_MC]        = LEN_W'(mc_only);
        amt[IX_BC_B]      = bc_only ? payload : '0;
        amt[IX_MC_B]      = mc_only ? payload : '0;
        amt[IX_PAUSE]     = LEN_W'(good && fs.pause);
        amt[IX_CTRL]      = LEN_W'(good && fs.ctrl && !fs.pause);
        for (int k = 0; k < NUM_BIN; k++) begin
            amt[IX_BIN0 + k] = LEN_W'(good && in_bin[k]);
        end
    end

    // R5, R6: a summary resolves to at most one outcome class
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({good, over, short_f, fcs_bad, fs.valid && drop}));

    // R3: a good frame lands in exactly one bin
    p_one_bin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        good |-> $countones(amt[IX_BIN0 +: NUM_BIN]) == 1);

endmodule

// File: rtl/rx_stat_cell.sv
module rx_stat_cell #(
    parameter int CNT_W = 32,
    parameter int AMT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [AMT_W-1:0] amt,
    output logic [CNT_W-1:0] cnt
);

    localparam int SUM_W = ((CNT_W > AMT_W) ? CNT_W : AMT_W) + 1;
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cell_st_t;

    cell_st_t         st_d, st_q;
    logic [CNT_W-1:0] base;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        base = clr ? '0 : st_q.cnt;
        sum  = SUM_W'(base) + SUM_W'(amt);
        if (sum > SUM_W'(MAXV)) begin
            st_d.cnt = MAXV;
        end else begin
            st_d.cnt = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R12: saturated value is held until a read clears it
    p_sat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> cnt == MAXV);

    // R12: without a clear the count never goes down
    p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));

    // R10: a clear with no event leaves zero
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && amt == '0) |=> cnt == '0);

endmodule

// File: rtl/rx_stat_rdport.sv
module rx_stat_rdport
    import rx_stat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_stb,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    output logic [NUM_CNT-1:0]            clr,
    output logic                          rd_valid,
    output logic [CNT_W-1:0]              rd_data
);

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;

    genvar k;
    generate
        for (k = 0; k < NUM_CNT; k++) begin : g_clr
            assign clr[k] = rd_stb && (rd_idx == IDX_W'(k));
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_stb;
        st_d.data  = '0;
        if (rd_stb && (int'(rd_idx) < NUM_CNT)) begin
            st_d.data = cnt[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;

    // R9: one-cycle read latency
    p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    // R9: no spurious valid
    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);

    // R9: unmapped indices read as zero
    p_rd_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && int'(rd_idx) >= NUM_CNT) |=> rd_data == '0);

endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
    import rx_stat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_valid,
    input  logic [LEN_W-1:0]   frm_len,
    input  logic               frm_fcs_ok,
    input  logic               frm_bcast,
    input  logic               frm_mcast,
    input  logic               frm_pause,
    input  logic               frm_ctrl,
    input  logic               frm_len_mis,
    input  logic               frm_align_err,
    input  logic               frm_drop_fifo,
    input  logic               frm_drop_desc,
    input  logic               frm_drop_filt,
    input  logic [LEN_W-1:0]   mtu,
    input  logic               rd_stb,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data
);

    frame_sum_t                     fs;
    logic [NUM_CNT-1:0][LEN_W-1:0]  amt;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
    logic [NUM_CNT-1:0]             clr;

    always_comb begin
        fs.valid     = frm_valid;
        fs.len       = frm_len;
        fs.fcs_ok    = frm_fcs_ok;
        fs.bcast     = frm_bcast;
        fs.mcast     = frm_mcast;
        fs.pause     = frm_pause;
        fs.ctrl      = frm_ctrl;
        fs.len_mis   = frm_len_mis;
        fs.align     = frm_align_err;
        fs.drop_fifo = frm_drop_fifo;
        fs.drop_desc = frm_drop_desc;
        fs.drop_filt = frm_drop_filt;
    end

    rx_stat_classify u_classify (
        .clk   (clk),
        .rst_n (rst_n),
        .fs    (fs),
        .mtu   (mtu),
        .amt   (amt)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_CNT; k++) begin : g_cnt
            rx_stat_cell #(
                .CNT_W (CNT_W),
                .AMT_W (LEN_W)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr[k]),
                .amt   (amt[k]),
                .cnt   (cnt[k])
            );
        end
    endgenerate

    rx_stat_rdport #(
        .CNT_W (CNT_W)
    ) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .rd_idx   (rd_idx),
        .cnt      (cnt),
        .clr      (clr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R6: a dropped frame never moves the good-frame counter
    p_drop_not_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (frm_drop_fifo || frm_drop_desc || frm_drop_filt) && !clr[IX_GOOD])
        |=> $stable(cnt[IX_GOOD]));

endmodule

// File: tb/rx_stat_bank_bench.sv
module rx_stat_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 12;
    localparam int NC         = 24;
    localparam int MTU_V      = 1600;
    localparam int MAXV       = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frm_valid = 0;
    logic [13:0]     frm_len = '0;
    logic            frm_fcs_ok = 0, frm_bcast = 0, frm_mcast = 0, frm_pause = 0;
    logic            frm_ctrl = 0, frm_len_mis = 0, frm_align_err = 0;
    logic            frm_drop_fifo = 0, frm_drop_desc = 0, frm_drop_filt = 0;
    logic [13:0]     mtu = 14'(MTU_V);
    logic            rd_stb = 0;
    logic [4:0]      rd_idx = '0;
    logic            rd_valid;
    logic [CW-1:0]   rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int ref_cnt [NC];
    bit exp_valid = 0;
    int exp_data = 0;
    string exp_tag = "";
    string tag_force = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_stat_bank #(.CNT_W(CW)) u_rx_stat_bank (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
        .frm_fcs_ok(frm_fcs_ok), .frm_bcast(frm_bcast), .frm_mcast(frm_mcast),
        .frm_pause(frm_pause), .frm_ctrl(frm_ctrl), .frm_len_mis(frm_len_mis),
        .frm_align_err(frm_align_err), .frm_drop_fifo(frm_drop_fifo),
        .frm_drop_desc(frm_drop_desc), .frm_drop_filt(frm_drop_filt), .mtu(mtu),
        .rd_stb(rd_stb), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic string tag_of(int idx);
        if (idx == 0 || idx == 2 || idx == 3) return "R1";
        if (idx == 1 || idx == 4 || idx == 5) return "R2";
        if (idx == 6 || idx == 7) return "R7";
        if (idx >= 8 && idx <= 10) return "R8";
        if (idx == 11 || idx == 12) return "R4";
        if (idx == 13) return "R5";
        if (idx >= 14 && idx <= 16) return "R6";
        if (idx >= 17 && idx < NC) return "R3";
        return "R9";
    endfunction

    // behavioural expectation of what this summary adds to each counter
    function automatic void frame_effect(output int inc [NC]);
        int len = int'(frm_len);
        bit dropped = frm_drop_fifo || frm_drop_desc || frm_drop_filt;
        bit ok;
        for (int i = 0; i < NC; i++) inc[i] = 0;
        if (!frm_valid) return;
        if (dropped) begin
            if (frm_drop_fifo) inc[14] = 1;
            if (frm_drop_desc) inc[15] = 1;
            if (frm_drop_filt) inc[16] = 1;
            return;
        end
        if (frm_len_mis)   inc[9]  = 1;
        if (frm_align_err) inc[10] = 1;
        if (len > MTU_V) begin
            inc[13] = 1;
            return;
        end
        if (len < 64) begin
            if (frm_fcs_ok) inc[11] = 1; else inc[12] = 1;
            return;
        end
        if (!frm_fcs_ok) begin
            inc[8] = 1;
            return;
        end
        ok = !frm_len_mis && !frm_align_err;
        if (!ok) return;
        inc[0] = 1;
        inc[1] = len - 4;
        if (frm_bcast) begin
            inc[2] = 1; inc[4] = len - 4;
        end else if (frm_mcast) begin
            inc[3] = 1; inc[5] = len - 4;
        end
        if (frm_pause) inc[6] = 1;
        else if (frm_ctrl) inc[7] = 1;
        if (len == 64) inc[17] = 1;
        else if (len <= 127) inc[18] = 1;
        else if (len <= 255) inc[19] = 1;
        else if (len <= 511) inc[20] = 1;
        else if (len <= 1023) inc[21] = 1;
        else if (len <= 1518) inc[22] = 1;
        else inc[23] = 1;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model at the edge, compare at the following falling edge
    task automatic tick();
        int inc [NC];
        int idx;
        @(posedge clk);
        frame_effect(inc);
        idx = int'(rd_idx);
        exp_valid = rd_stb;
        exp_data  = 0;
        exp_tag   = "R9";
        if (rd_stb && idx < NC) begin
            exp_data = ref_cnt[idx];
            exp_tag  = tag_of(idx);
            if (inc[idx] != 0) exp_tag = "R11";
            else if (exp_data == MAXV) exp_tag = "R12";
        end
        if (tag_force != "") exp_tag = tag_force;
        for (int i = 0; i < NC; i++) begin
            int base = (rd_stb && idx == i) ? 0 : ref_cnt[i];
            int s = base + inc[i];
            ref_cnt[i] = (s > MAXV) ? MAXV : s;
        end
        @(negedge clk);
        check("R9 valid", int'(rd_valid), int'(exp_valid));
        if (exp_valid) check(exp_tag, int'(rd_data), exp_data);
    endtask

    task automatic idle_inputs();
        frm_valid = 0; frm_len = '0; frm_fcs_ok = 0; frm_bcast = 0; frm_mcast = 0;
        frm_pause = 0; frm_ctrl = 0; frm_len_mis = 0; frm_align_err = 0;
        frm_drop_fifo = 0; frm_drop_desc = 0; frm_drop_filt = 0;
        rd_stb = 0; rd_idx = '0;
    endtask

    task automatic good_frame(int len, bit bc, bit mc, bit pz, bit ct);
        idle_inputs();
        frm_valid = 1; frm_len = 14'(len); frm_fcs_ok = 1;
        frm_bcast = bc; frm_mcast = mc; frm_pause = pz; frm_ctrl = ct;
        tick();
    endtask

    task automatic read_one(int idx, string tg);
        idle_inputs();
        rd_stb = 1; rd_idx = 5'(idx);
        tag_force = tg;
        tick();
        tag_force = "";
        idle_inputs();
    endtask

    task automatic read_all();
        for (int i = 0; i < 32; i++) read_one(i, "");
        idle_inputs();
        tick();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NC; i++) ref_cnt[i] = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R13 valid", int'(rd_valid), 0);
        rst_n = 1;
        @(negedge clk);
        // R13: everything zero after reset, R9: unmapped indices zero
        for (int i = 0; i < 32; i++) read_one(i, (i < NC) ? "R13" : "R9");

        // R1 R2 R3: one good frame per bin edge
        good_frame(64, 0, 0, 0, 0);
        good_frame(65, 0, 0, 0, 0);
        good_frame(127, 0, 0, 0, 0);
        good_frame(128, 1, 0, 0, 0);
        good_frame(255, 0, 1, 0, 0);
        good_frame(256, 1, 1, 0, 0);
        good_frame(511, 0, 0, 0, 0);
        good_frame(512, 0, 0, 0, 0);
        good_frame(1023, 0, 0, 0, 0);
        good_frame(1024, 0, 0, 0, 0);
        good_frame(1518, 0, 0, 0, 0);
        good_frame(1519, 0, 0, 0, 0);
        good_frame(MTU_V, 0, 0, 0, 0);
        // R7: pause, control, both
        good_frame(64, 0, 1, 1, 0);
        good_frame(80, 0, 1, 0, 1);
        good_frame(90, 0, 1, 1, 1);
        // R4: runt and fragment, R5: oversize
        idle_inputs(); frm_valid = 1; frm_len = 14'd63; frm_fcs_ok = 1; tick();
        idle_inputs(); frm_valid = 1; frm_len = 14'd40; frm_fcs_ok = 0; tick();
        idle_inputs(); frm_valid = 1; frm_len = 14'(MTU_V + 1); frm_fcs_ok = 1; tick();
        // R8: FCS error, length mismatch, alignment error
        idle_inputs(); frm_valid = 1; frm_len = 14'd500; frm_fcs_ok = 0; tick();
        idle_inputs(); frm_valid = 1; frm_len = 14'd500; frm_fcs_ok = 1; frm_len_mis = 1; tick();
        idle_inputs(); frm_valid = 1; frm_len = 14'd300; frm_fcs_ok = 1; frm_align_err = 1; tick();
        // R6: drops, including a good-looking frame that is dropped
        idle_inputs(); frm_valid = 1; frm_len = 14'd100; frm_fcs_ok = 1; frm_drop_fifo = 1; tick();
        idle_inputs(); frm_valid = 1; frm_len = 14'd100; frm_fcs_ok = 1; frm_drop_desc = 1; frm_bcast = 1; tick();
        idle_inputs(); frm_valid = 1; frm_len = 14'd30;  frm_drop_filt = 1; tick();
        read_all();
        // R10: a second read returns zero
        read_one(0, "R10");
        read_one(17, "R10");

        // R11: read and increment of the same counter in one cycle
        good_frame(200, 0, 0, 0, 0);
        idle_inputs(); frm_valid = 1; frm_len = 14'd200; frm_fcs_ok = 1;
        rd_stb = 1; rd_idx = 5'd0; tag_force = "R11"; tick(); tag_force = "";
        read_one(0, "R11");

        // random overlap of reads and summaries
        for (int n = 0; n < 3000; n++) begin
            int pick;
            idle_inputs();
            frm_valid = ($urandom_range(3, 0) != 0);
            pick = $urandom_range(5, 0);
            case (pick)
                0: frm_len = 14'($urandom_range(70, 20));
                1: frm_len = 14'($urandom_range(1530, 1500));
                2: frm_len = 14'($urandom_range(MTU_V + 20, MTU_V - 20));
                default: frm_len = 14'($urandom_range(1600, 60));
            endcase
            frm_fcs_ok    = ($urandom_range(7, 0) != 0);
            frm_bcast     = ($urandom_range(3, 0) == 0);
            frm_mcast     = ($urandom_range(3, 0) == 0);
            frm_pause     = ($urandom_range(7, 0) == 0);
            frm_ctrl      = ($urandom_range(7, 0) == 0);
            frm_len_mis   = ($urandom_range(15, 0) == 0);
            frm_align_err = ($urandom_range(15, 0) == 0);
            frm_drop_fifo = ($urandom_range(15, 0) == 0);
            frm_drop_desc = ($urandom_range(15, 0) == 0);
            frm_drop_filt = ($urandom_range(15, 0) == 0);
            rd_stb        = ($urandom_range(2, 0) == 0);
            rd_idx        = 5'($urandom_range(31, 0));
            tick();
        end
        read_all();

        // R12: push past the maximum without reading
        for (int n = 0; n < MAXV + 40; n++) good_frame(1518, 1, 0, 0, 0);
        read_one(0, "R12");
        read_one(1, "R12");
        read_one(22, "R12");
        read_all();
        finish_run();
    end

endmodule